// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-facing register file of a simple LCD panel controller. A 32-bit bus reads and writes words by word index. Six words are mapped: control, three timing words, a status word and a subpanel word. Writes pass through fixed write masks, and reads OR in fixed constant bits. Reads are combinational in the cycle of the read strobe. Any read or write to an unmapped word returns zero and raises a one-cycle bad-register pulse in the following cycle.

Three sticky status flags (frame done, palette done, sync error) are set by pulses from the scanout engine. A control write that changes the enable bit also acts on them. Disabling clears sync error, and it sets frame done unless the new palette-load mode is the palette-only value 1. Enabling clears frame done and palette done. The flags drive a single registered level interrupt. Frame done and palette done each have their own enable bit, and sync error cannot be masked.

Top module: `lcdr_ctrl_regs`

## Requirements
- R1: After reset, control reads 0xFE000C34, timing0 reads 0x0000000F, timing1 reads 0, timing2 reads 0xFC000000, status reads 0 and subpanel reads 0. irq_o and bad_reg_o are 0.
- R2: In the control word (index 0), bit 0 is enable, bit 1 is mono, bits 4:3 are the interrupt enables, bit 7 is the panel-type bit and bits 21:20 are the palette-load mode. All other written bits are kept under mask 0x01CFF300. A read returns these fields, the panel-type bit copied to bit 23 as well, ORed with 0xFE000C34.
- R3: Timing0 (index 1) and timing1 (index 2) store all 32 bits. Bits 9:0 hold width-1 and height-1, and bits 31:10 are held separately. A timing0 read ORs in 0x0000000F. Timing2 (index 3) stores 32 bits and reads back ORed with 0xFC000000.
- R4: Subpanel (index 5) stores the written value ANDed with 0xA1FFFFFF.
- R5: A status read (index 4) returns frame done at bit 0, sync error at bit 2 and palette done at bit 6. All other bits read 0. Each flag is set by a one-cycle pulse on its set input.
- R6: A write to the status word has no effect on any flag.
- R7: If frame done is set and interrupt-enable bit 3 is set, irq_o is 1 one cycle after the condition arises.
- R8: If palette done is set and interrupt-enable bit 4 is set, irq_o is 1 one cycle later. Palette done alone, with only bit 3 enabled, leaves irq_o at 0.
- R9: Sync error raises irq_o one cycle later whatever the enable bits are. With no enabled flag set, irq_o falls one cycle after the last cause goes away.
- R10: A control write that changes enable from 1 to 0 clears sync error. It also sets frame done, unless the written mode bits 21:20 equal 1.
- R11: A control write that changes enable from 0 to 1 clears frame done and palette done. Sync error is left unchanged.
- R12: If a set input and a clear caused by a control write arrive in the same cycle, the set input wins.
- R13: An access to a word index of 6 or above reads 0, and bad_reg_o pulses high in the next cycle. An access to a mapped word leaves bad_reg_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | AW | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when rd_en_i is low |
| frame_done_set_i | input | 1 | Frame-done set pulse from scanout |
| palette_done_set_i | input | 1 | Palette-done set pulse from scanout |
| sync_err_set_i | input | 1 | Sync-error set pulse from scanout |
| irq_o | output | 1 | Registered level interrupt |
| bad_reg_o | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The bench builds the block with the default AW = 6, so the address space holds 64 words. The unmapped area from index 6 up to the top index 63 can then be reached, and both ends of it are probed for the bad-register pulse and the zero read. The same width leaves every mapped index reachable for the mask, mirror and constant-bit readback patterns. The timing of the enable edges is driven directly, including disable with and without palette-only mode and set pulses that land in the same cycle as a control write.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned NREG  = 6;
  localparam int unsigned NFLAG = 3;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_TIM0 = 3'd1,
    REG_TIM1 = 3'd2,
    REG_TIM2 = 3'd3,
    REG_STAT = 3'd4,
    REG_SUBP = 3'd5
  } reg_idx_e;

  localparam int FLG_FRAME = 0;
  localparam int FLG_PAL   = 1;
  localparam int FLG_SYNC  = 2;

  localparam logic [DW-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
  localparam logic [DW-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
  localparam logic [DW-1:0] TIM0_RD_ONES   = 32'h0000_000F;
  localparam logic [DW-1:0] TIM2_RD_ONES   = 32'hFC00_0000;
  localparam logic [DW-1:0] SUBP_MASK      = 32'hA1FF_FFFF;
  localparam logic [1:0]    MODE_PAL_ONLY  = 2'd1;
endpackage

// File: rtl/lcdr_regfile.sv
module lcdr_regfile
  import lcdr_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic [DW-1:0]    rdata_o,
  output logic             bad_reg_o,
  output logic [1:0]       ie_o,
  output logic [NFLAG-1:0] flag_set_o,
  output logic [NFLAG-1:0] flag_clr_o
);
  localparam int unsigned FW = 10;
  localparam int unsigned HW = DW - FW;

  logic          en_q, mono_q, tft_q;
  logic [1:0]    ie_q, mode_q;
  logic [DW-1:0] keep_q, tim2_q, subp_q;
  logic [FW-1:0] tim0_lo_q, tim1_lo_q;
  logic [HW-1:0] tim0_hi_q, tim1_hi_q;
  logic          bad_q;
  logic          mapped, ctrl_wr;

  assign mapped  = addr_i < AW'(NREG);
  assign ctrl_wr = wr_en_i && (addr_i == AW'(REG_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      mono_q    <= 1'b0;
      tft_q     <= 1'b0;
      ie_q      <= '0;
      mode_q    <= '0;
      keep_q    <= '0;
      tim0_lo_q <= '0;
      tim0_hi_q <= '0;
      tim1_lo_q <= '0;
      tim1_hi_q <= '0;
      tim2_q    <= '0;
      subp_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        AW'(REG_CTRL): begin
          en_q   <= wdata_i[0];
          mono_q <= wdata_i[1];
          ie_q   <= wdata_i[4:3];
          tft_q  <= wdata_i[7];
          mode_q <= wdata_i[21:20];
          keep_q <= wdata_i & CTRL_KEEP_MASK;
        end
        AW'(REG_TIM0): begin
          tim0_lo_q <= wdata_i[FW-1:0];
          tim0_hi_q <= wdata_i[DW-1:FW];
        end
        AW'(REG_TIM1): begin
          tim1_lo_q <= wdata_i[FW-1:0];
          tim1_hi_q <= wdata_i[DW-1:FW];
        end
        AW'(REG_TIM2): tim2_q <= wdata_i;
        AW'(REG_SUBP): subp_q <= wdata_i & SUBP_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_q <= 1'b0;
    else         bad_q <= (rd_en_i || wr_en_i) && !mapped;
  end

  // enable edges act on the sticky flags
  always_comb begin
    flag_set_o = '0;
    flag_clr_o = '0;
    if (ctrl_wr && en_q && !wdata_i[0]) begin
      flag_clr_o[FLG_SYNC] = 1'b1;
      if (wdata_i[21:20] != MODE_PAL_ONLY) flag_set_o[FLG_FRAME] = 1'b1;
    end
    if (ctrl_wr && !en_q && wdata_i[0]) begin
      flag_clr_o[FLG_FRAME] = 1'b1;
      flag_clr_o[FLG_PAL]   = 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        AW'(REG_CTRL): rdata_o = keep_q | CTRL_RD_ONES
                               | (DW'(tft_q) << 23) | (DW'(mode_q) << 20)
                               | (DW'(tft_q) << 7) | (DW'(ie_q) << 3)
                               | (DW'(mono_q) << 1) | DW'(en_q);
        AW'(REG_TIM0): rdata_o = {tim0_hi_q, tim0_lo_q} | TIM0_RD_ONES;
        AW'(REG_TIM1): rdata_o = {tim1_hi_q, tim1_lo_q};
        AW'(REG_TIM2): rdata_o = tim2_q | TIM2_RD_ONES;
        AW'(REG_STAT): rdata_o = (DW'(flags_i[FLG_PAL]) << 6)
                               | (DW'(flags_i[FLG_SYNC]) << 2)
                               | DW'(flags_i[FLG_FRAME]);
        AW'(REG_SUBP): rdata_o = subp_q;
        default:       rdata_o = '0;
      endcase
    end
  end

  assign bad_reg_o = bad_q;
  assign ie_o      = ie_q;

  // R13
  bad_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i) && !mapped |=> bad_reg_o);
  // R13
  no_bad_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i || wr_en_i) |=> !bad_reg_o);
  // R2
  ctrl_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == AW'(REG_CTRL) |-> (rdata_o & CTRL_RD_ONES) == CTRL_RD_ONES);
endmodule

// File: rtl/lcdr_flags.sv
module lcdr_flags
  import lcdr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flag_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    // R12
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    // R6
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_i[i] && !clr_i[i] |=> flag_q[i] == $past(flag_q[i]));
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/lcdr_irq.sv
module lcdr_irq
  import lcdr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [1:0]       ie_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= (flags_i[FLG_FRAME] && ie_i[0]) ||
                  (flags_i[FLG_PAL] && ie_i[1]) ||
                  flags_i[FLG_SYNC];
  end

  assign irq_o = irq_q;

  // R9
  sync_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[FLG_SYNC] |=> irq_o);
  // R7
  frame_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[FLG_FRAME] && ie_i[0] |=> irq_o);
  // R8
  pal_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[FLG_PAL] && ie_i[1] |=> irq_o);
  // R9
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i == '0 |=> !irq_o);
endmodule

// File: rtl/lcdr_ctrl_regs.sv
module lcdr_ctrl_regs
  import lcdr_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          frame_done_set_i,
  input  logic          palette_done_set_i,
  input  logic          sync_err_set_i,
  output logic          irq_o,
  output logic          bad_reg_o
);
  logic [NFLAG-1:0] flags, sw_set, sw_clr, all_set;
  logic [1:0]       ie;

  assign all_set = sw_set | {sync_err_set_i, palette_done_set_i, frame_done_set_i};

  lcdr_regfile #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .flags_i    (flags),
    .rdata_o    (rdata_o),
    .bad_reg_o  (bad_reg_o),
    .ie_o       (ie),
    .flag_set_o (sw_set),
    .flag_clr_o (sw_clr)
  );

  lcdr_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (all_set),
    .clr_i   (sw_clr),
    .flags_o (flags)
  );

  lcdr_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .ie_i    (ie),
    .irq_o   (irq_o)
  );

  // R6
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == AW'(REG_STAT) && !frame_done_set_i &&
    !palette_done_set_i && !sync_err_set_i |=> $stable(flags));
endmodule

// File: tb/tb_lcdr_ctrl_regs.sv
module tb_lcdr_ctrl_regs;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          fd_set = 1'b0, pd_set = 1'b0, se_set = 1'b0;
  logic          irq, bad_reg;
  int            n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  lcdr_ctrl_regs #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .frame_done_set_i(fd_set), .palette_done_set_i(pd_set),
    .sync_err_set_i(se_set), .irq_o(irq), .bad_reg_o(bad_reg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    tick();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    tick();
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input int a, input logic [31:0] exp);
    tick();
    addr = AW'(a); rd_en = 1'b1;
    #1;
    chk(req, rdata, exp);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic f, input logic p, input logic s);
    tick();
    fd_set = f; pd_set = p; se_set = s;
    tick();
    fd_set = 1'b0; pd_set = 1'b0; se_set = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 bad", 32'(bad_reg), 0);
    rd("R1 ctrl", 0, 32'hFE000C34);
    rd("R1 tim0", 1, 32'h0000000F);
    rd("R1 tim1", 2, 32'h0);
    rd("R1 tim2", 3, 32'hFC000000);
    rd("R1 stat", 4, 32'h0);
    rd("R1 subp", 5, 32'h0);
  endtask

  task automatic t_ctrl();
    do_reset();
    wr(0, 32'hFFFFFFFE);
    rd("R2 all", 0, 32'hFFFFFFBE);
    wr(0, 32'h00000080);
    rd("R2 mirror", 0, 32'hFE800CB4);
    wr(0, 32'h00800000);
    rd("R2 keep23", 0, 32'hFE800C34);
    wr(0, 32'h00100002);
    rd("R2 mode_mono", 0, 32'hFE100C36);
  endtask

  task automatic t_timing();
    do_reset();
    wr(1, 32'h12345670);
    rd("R3 tim0", 1, 32'h1234567F);
    wr(2, 32'hABCDEF01);
    rd("R3 tim1", 2, 32'hABCDEF01);
    wr(3, 32'h00001234);
    rd("R3 tim2", 3, 32'hFC001234);
    wr(5, 32'hFFFFFFFF);
    rd("R4 subp", 5, 32'hA1FFFFFF);
    wr(5, 32'h5E000001);
    rd("R4 subp2", 5, 32'h00000001);
  endtask

  task automatic t_status();
    do_reset();
    pulse(1, 0, 0);
    rd("R5 fd", 4, 32'h1);
    pulse(0, 0, 1);
    rd("R5 se", 4, 32'h5);
    pulse(0, 1, 0);
    rd("R5 pd", 4, 32'h45);
    wr(4, 32'h00000000);
    rd("R6 wr0", 4, 32'h45);
    do_reset();
    wr(4, 32'hFFFFFFFF);
    rd("R6 wr1", 4, 32'h0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(0, 32'h08);
    pulse(1, 0, 0);
    chk("R7 latency", 32'(irq), 0);
    tick();
    chk("R7 fd irq", 32'(irq), 1);
    wr(0, 32'h00);
    tick();
    chk("R9 fall", 32'(irq), 0);
    do_reset();
    wr(0, 32'h10);
    pulse(0, 1, 0);
    tick();
    chk("R8 pd irq", 32'(irq), 1);
    do_reset();
    wr(0, 32'h08);
    pulse(0, 1, 0);
    tick();
    chk("R8 pd masked", 32'(irq), 0);
    do_reset();
    pulse(0, 0, 1);
    tick();
    chk("R9 sync", 32'(irq), 1);
  endtask

  task automatic t_enable();
    do_reset();
    wr(0, 32'h1);
    pulse(0, 0, 1);
    tick();
    chk("R9 sync en", 32'(irq), 1);
    wr(0, 32'h0);
    rd("R10 fall", 4, 32'h1);
    chk("R10 irq", 32'(irq), 0);
    wr(0, 32'h09);
    rd("R11 rise", 4, 32'h0);
    wr(0, 32'h00100008);
    rd("R10 palonly", 4, 32'h0);
    rd("R10 ctrl", 0, 32'hFE100C3C);
    do_reset();
    pulse(1, 1, 1);
    wr(0, 32'h1);
    rd("R11 keep se", 4, 32'h4);
  endtask

  task automatic t_race();
    do_reset();
    wr(0, 32'h1);
    tick();
    addr = AW'(0); wdata = 32'h0; wr_en = 1'b1; se_set = 1'b1;
    tick();
    wr_en = 1'b0; se_set = 1'b0;
    rd("R12 se wins", 4, 32'h5);
    tick();
    addr = AW'(0); wdata = 32'h1; wr_en = 1'b1; fd_set = 1'b1;
    tick();
    wr_en = 1'b0; fd_set = 1'b0;
    rd("R12 fd wins", 4, 32'h5);
  endtask

  task automatic t_unmapped();
    do_reset();
    rd("R13 rd8", 8, 32'h0);
    chk("R13 bad8", 32'(bad_reg), 1);
    tick();
    chk("R13 bad clr", 32'(bad_reg), 0);
    rd("R13 rd63", 63, 32'h0);
    chk("R13 bad63", 32'(bad_reg), 1);
    wr(7, 32'hFFFFFFFF);
    chk("R13 badwr", 32'(bad_reg), 1);
    rd("R13 mapped", 5, 32'h0);
    chk("R13 nobad", 32'(bad_reg), 0);
  endtask

  initial begin
    t_reset();
    t_ctrl();
    t_timing();
    t_status();
    t_irq();
    t_enable();
    t_race();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule